// File: doc/BRIEF.md
# Ultrasonic Ranging Sensor Controller

This block drives an external time-of-flight ultrasonic ranging sensor. It runs from a single system clock and uses a one-cycle enable tick as its microsecond timebase, so it needs no derived clock. At a fixed repetition interval it raises a trigger pulse. It then times how long the returned echo line stays high and turns that width into a distance in thousandths of a centimetre. The flight time is halved for the round trip, which gives 17 distance units per microsecond, and the multiply by 17 is a shift plus an add.

The asynchronous echo line passes through a synchronizer before edge detection, and edges are detected at the system clock rate. An echo counts only if it rises after the trigger pulse of the current interval has ended. When an echo stays high too long, or when it is still high as the next trigger starts, the block still delivers a result and flags it as out of range. Each new result comes with a one-clock valid strobe, and the distance is held until the next result.

Top module: `ultrasonic_ranger`

## Requirements
- R1: While reset is held and after its release, until the first result, `distance` is 0, `distValid` is 0 and `overRange` is 0.
- R2: One microsecond is TICK_DIV clocks. `trigOut` is high for the first TRIG_US microseconds of every PERIOD_US-microsecond interval (defaults 50, 12 and 300000). The first interval starts at reset release, so `trigOut` is high at once.
- R3: An accepted echo that is high for N whole microseconds, with N below MAX_US, gives `distance` = 17·N and `overRange` = 0, as long as 17·N fits in DIST_W bits.
- R4: Each result pulses `distValid` for exactly one clock. For a normal result the pulse starts on the third clock edge after the echo line falls.
- R5: An accepted echo that is high for MAX_US microseconds or longer (default 60000) gives `overRange` = 1 and `distance` = all ones. The width count stops at MAX_US and does not wrap.
- R6: If 17·N does not fit in DIST_W bits, the result is reported as in R5: `overRange` = 1 and `distance` = all ones.
- R7: An echo that rises while `trigOut` is high is ignored. Its fall produces no `distValid`, and `distance` and `overRange` keep their values.
- R8: If an accepted echo is still high when the next interval starts, `distValid` pulses on the same clock edge at which `trigOut` rises, with `overRange` = 1 and `distance` all ones. The later fall of that echo produces no further result.
- R9: `distance` and `overRange` change only on the clock edge that raises `distValid`, and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| echoIn | input | 1 | Echo line from the sensor, asynchronous |
| trigOut | output | 1 | Trigger pulse to the sensor |
| distance | output | DIST_W | Last distance in thousandths of a centimetre |
| distValid | output | 1 | One-clock strobe marking a new result |
| overRange | output | 1 | Last result was out of range or did not fit |

## Verification
A wrong timebase or interval count shows first on `trigOut`: the high time or the repetition interval moves by whole microseconds, and this is visible within a single interval. A wrong width count or product shows on `distance` at the next result, as a value that is not 17 times the stimulus width. A fault in the acceptance flag shows up in two ways. A missing or extra `distValid` pulse appears within a few clocks of an echo edge, or a false out-of-range result appears on the edge where the trigger rises.

// File: rtl/ranger_pkg.sv
package ranger_pkg;

  // Strobes passed from the control unit to the datapath each clock.
  typedef struct packed {
    logic tick;      // one-cycle microsecond enable
    logic echoHigh;  // synchronized echo level
    logic capture;   // accepted echo just fell: store the measured result
    logic forceOver; // accepted echo still high at interval start
  } rangerCtrl_t;

endpackage

// File: rtl/ranger_ctrl.sv
module ranger_ctrl
  import ranger_pkg::*;
#(
  parameter int TICK_DIV    = 50,
  parameter int PERIOD_US   = 300000,
  parameter int TRIG_US     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        echoIn,
  output logic        trigOut,
  output rangerCtrl_t ctrl
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PER_W = (PERIOD_US > 1) ? $clog2(PERIOD_US) : 1;

  logic [DIV_W-1:0]     divCnt;
  logic [PER_W-1:0]     perCnt;
  logic [SYNC_STAGES:0] syncQ;
  logic                 armed;

  logic tick, periodEnd, trigActive;
  logic echoLvl, echoPrev, echoRise, echoFall;

  // microsecond enable
  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // repetition interval, counted in microseconds
  assign periodEnd  = tick && (perCnt == PER_W'(PERIOD_US - 1));
  assign trigActive = (perCnt < PER_W'(TRIG_US));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          perCnt <= '0;
    else if (periodEnd) perCnt <= '0;
    else if (tick)      perCnt <= perCnt + 1'b1;
  end

  assign trigOut = trigActive;

  // echo synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], echoIn};
  end

  assign echoLvl  = syncQ[SYNC_STAGES-1];
  assign echoPrev = syncQ[SYNC_STAGES];
  assign echoRise = echoLvl & ~echoPrev;
  assign echoFall = ~echoLvl & echoPrev;

  // acceptance: echo must rise after the trigger pulse has ended
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          armed <= 1'b0;
    else if (ctrl.capture || ctrl.forceOver) armed <= 1'b0;
    else if (echoRise && !trigActive)   armed <= 1'b1;
  end

  always_comb begin
    ctrl.tick      = tick;
    ctrl.echoHigh  = echoLvl;
    ctrl.capture   = armed && echoFall;
    ctrl.forceOver = armed && periodEnd && !echoFall;
  end

endmodule

// File: rtl/ranger_datapath.sv
module ranger_datapath
  import ranger_pkg::*;
#(
  parameter int MAX_US = 60000,
  parameter int DIST_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  rangerCtrl_t       ctrl,
  output logic [DIST_W-1:0] distance,
  output logic              distValid,
  output logic              overRange
);

  localparam int CNT_W  = $clog2(MAX_US + 1);
  localparam int PROD_W = CNT_W + 5;
  localparam logic [DIST_W-1:0] ALL_ONES = {DIST_W{1'b1}};

  logic [CNT_W-1:0]  widthCnt;
  logic [PROD_W-1:0] product;
  logic [DIST_W-1:0] prodFit;
  logic              fits, saturated, badRange;

  // echo width in microseconds; clears while low, stops at the limit
  assign saturated = (widthCnt == CNT_W'(MAX_US));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       widthCnt <= '0;
    else if (!ctrl.echoHigh)         widthCnt <= '0;
    else if (ctrl.tick && !saturated) widthCnt <= widthCnt + 1'b1;
  end

  // times 17 as shift plus add
  assign product = ({5'b0, widthCnt} << 4) + {5'b0, widthCnt};

  generate
    if (PROD_W > DIST_W) begin : g_narrowOut
      assign fits    = ~|product[PROD_W-1:DIST_W];
      assign prodFit = product[DIST_W-1:0];
    end else begin : g_wideOut
      assign fits    = 1'b1;
      assign prodFit = DIST_W'(product);
    end
  endgenerate

  assign badRange = saturated || !fits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      distance  <= '0;
      overRange <= 1'b0;
      distValid <= 1'b0;
    end else begin
      distValid <= ctrl.capture || ctrl.forceOver;
      if (ctrl.forceOver) begin
        distance  <= ALL_ONES;
        overRange <= 1'b1;
      end else if (ctrl.capture) begin
        distance  <= badRange ? ALL_ONES : prodFit;
        overRange <= badRange;
      end
    end
  end

endmodule

// File: rtl/ultrasonic_ranger.sv
module ultrasonic_ranger
  import ranger_pkg::*;
#(
  parameter int TICK_DIV    = 50,
  parameter int PERIOD_US   = 300000,
  parameter int TRIG_US     = 12,
  parameter int MAX_US      = 60000,
  parameter int DIST_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              echoIn,
  output logic              trigOut,
  output logic [DIST_W-1:0] distance,
  output logic              distValid,
  output logic              overRange
);

  rangerCtrl_t ctrl;

  ranger_ctrl #(
    .TICK_DIV   (TICK_DIV),
    .PERIOD_US  (PERIOD_US),
    .TRIG_US    (TRIG_US),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .echoIn (echoIn),
    .trigOut(trigOut),
    .ctrl   (ctrl)
  );

  ranger_datapath #(
    .MAX_US(MAX_US),
    .DIST_W(DIST_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .distance (distance),
    .distValid(distValid),
    .overRange(overRange)
  );

endmodule

// File: rtl/ranger_checker.sv
module ranger_checker #(
  parameter int DIST_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              trigOut,
  input logic [DIST_W-1:0] distance,
  input logic              distValid,
  input logic              overRange
);

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    distValid |=> !distValid);

  // R5
  over_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (distance == {DIST_W{1'b1}}));

  // R3
  dist_mult_chk: assert property (@(posedge clk) disable iff (!rstN)
    (distValid && !overRange) |-> ((distance % 17) == 0));

  // R9
  dist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(distance) |-> distValid);

  // R9
  over_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(overRange) |-> distValid);

  // R2
  trig_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigOut) |=> trigOut);

endmodule

bind ultrasonic_ranger ranger_checker #(.DIST_W(DIST_W)) i_rangerChk (
  .clk      (clk),
  .rstN     (rstN),
  .trigOut  (trigOut),
  .distance (distance),
  .distValid(distValid),
  .overRange(overRange)
);

// File: tb/test_ultrasonic_ranger.sv
`timescale 1ns/1ps
module test_ultrasonic_ranger;

  localparam int DIV    = 5;
  localparam int PER    = 300;
  localparam int TRIG   = 12;
  localparam int MAXW   = 200;
  localparam int DW     = 19;
  localparam int NW     = 10;
  localparam int FULL   = (1 << DW) - 1;
  localparam int NFULL  = (1 << NW) - 1;

  typedef struct packed { int w; int d; bit o; } vec_t;
  localparam int VEC_N = 6;
  localparam vec_t VEC [VEC_N] = '{
    '{1,   17,   1'b0},
    '{7,   119,  1'b0},
    '{100, 1700, 1'b0},
    '{199, 3383, 1'b0},
    '{200, FULL, 1'b1},
    '{250, FULL, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic echoIn = 1'b0;
  logic trigOut, distValid, overRange;
  logic [DW-1:0] distance;
  logic trigN, validN, overN;
  logic [NW-1:0] distN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ultrasonic_ranger #(.TICK_DIV(DIV), .PERIOD_US(PER), .TRIG_US(TRIG),
                      .MAX_US(MAXW), .DIST_W(DW)) i_ultrasonic_ranger (
    .clk(clk), .rstN(rstN), .echoIn(echoIn), .trigOut(trigOut),
    .distance(distance), .distValid(distValid), .overRange(overRange));

  ultrasonic_ranger #(.TICK_DIV(DIV), .PERIOD_US(PER), .TRIG_US(TRIG),
                      .MAX_US(MAXW), .DIST_W(NW)) i_ultrasonic_ranger_narrow (
    .clk(clk), .rstN(rstN), .echoIn(echoIn), .trigOut(trigN),
    .distance(distN), .distValid(validN), .overRange(overN));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // counts distValid pulses over a window of clocks
  task automatic countValid(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (distValid) pulses++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int n, pulses;
    int held;
    repeat (4) @(posedge clk);
    #1;
    check(distance == 0 && !distValid && !overRange, "R1", "in reset",
          int'(distance) + int'(distValid) + int'(overRange), 0);
    @(negedge clk); rstN = 1'b1; #1;
    check(distance == 0 && !distValid && !overRange, "R1", "after release",
          int'(distance) + int'(distValid) + int'(overRange), 0);
    check(trigOut == 1'b1, "R2", "trigger at release", trigOut, 1);

    // R2 trigger high time and interval
    n = 0;
    while (trigOut) begin @(posedge clk); #1; n++; end
    check(n == TRIG * DIV, "R2", "trigger high clocks", n, TRIG * DIV);
    n = 0;
    while (!trigOut) begin @(posedge clk); #1; n++; end
    check(n == (PER - TRIG) * DIV, "R2", "trigger low clocks", n, (PER - TRIG) * DIV);

    // vector table: R3, R4, R5, R6, R9
    for (int v = 0; v < VEC_N; v++) begin
      int nExp; bit nOver;
      nOver = VEC[v].o || (17 * VEC[v].w > NFULL);
      nExp  = nOver ? NFULL : 17 * VEC[v].w;
      @(negedge trigOut); #1;
      echoIn = 1'b1;
      repeat (VEC[v].w * DIV) @(posedge clk);
      #1; echoIn = 1'b0;
      repeat (2) @(posedge clk); #1;
      check(!distValid, "R4", "no strobe before third edge", distValid, 0);
      @(posedge clk); #1;
      check(distValid == 1'b1, "R4", "strobe on third edge", distValid, 1);
      check(distance == VEC[v].d, VEC[v].o ? "R5" : "R3", "distance",
            int'(distance), VEC[v].d);
      check(overRange == VEC[v].o, "R5", "over flag", overRange, VEC[v].o);
      check(int'(distN) == nExp && overN == nOver, "R6", "narrow distance",
            int'(distN), nExp);
      @(posedge clk); #1;
      check(!distValid, "R4", "strobe one clock", distValid, 0);
      held = int'(distance);
      repeat (20) @(posedge clk); #1;
      check(int'(distance) == held && overRange == VEC[v].o, "R9", "hold",
            int'(distance), held);
    end

    // R7 echo rising during trigger is ignored
    held = int'(distance);
    @(posedge trigOut); #1;
    repeat (5) @(posedge clk); #1;
    echoIn = 1'b1;
    repeat (100) @(posedge clk); #1;
    echoIn = 1'b0;
    countValid(20, pulses);
    check(pulses == 0, "R7", "no strobe", pulses, 0);
    check(int'(distance) == held && overRange == 1'b1, "R7", "distance kept",
          int'(distance), held);

    // R3 a normal result first so the forced result is visible
    @(negedge trigOut); #1;
    echoIn = 1'b1;
    repeat (30 * DIV) @(posedge clk);
    #1; echoIn = 1'b0;
    repeat (3) @(posedge clk); #1;
    check(distValid && distance == 510 && !overRange, "R3", "width 30",
          int'(distance), 510);

    // R8 echo still high at next trigger
    @(negedge trigOut); #1;
    echoIn = 1'b1;
    @(posedge trigOut); #1;
    check(distValid == 1'b1, "R8", "strobe at trigger rise", distValid, 1);
    check(overRange && distance == FULL, "R8", "forced over", int'(distance), FULL);
    @(posedge clk); #1;
    check(!distValid, "R8", "strobe one clock", distValid, 0);
    @(negedge trigOut); #1;
    repeat (10) @(posedge clk); #1;
    echoIn = 1'b0;
    countValid(20, pulses);
    check(pulses == 0, "R8", "late fall ignored", pulses, 0);

    // R3 accepted again after forced result
    @(negedge trigOut); #1;
    echoIn = 1'b1;
    repeat (3 * DIV) @(posedge clk);
    #1; echoIn = 1'b0;
    repeat (3) @(posedge clk); #1;
    check(distValid && distance == 51 && !overRange, "R3", "rearmed width 3",
          int'(distance), 51);

    finishRun();
  end

endmodule